// File: doc/BRIEF.md
# Segmented Bounded-Run Program Counter

This block forms instruction fetch addresses from two registers instead of a single flat counter. A 16-bit base register holds the address of the most recent control-transfer target. A narrow step counter counts the bytes fetched since that target. The fetch address is always the sum of the two, wrapping modulo 2^16. A taken branch, call or return writes its destination into the base register and zeroes the step counter. Straight-line execution is therefore confined to a short window above each target.

The step counter never wraps. When it reaches its top value, the block reports a trap on a one-cycle fault-reset output meant for the processor core. In the same clock edge it reloads its own registers with the reset vector. A sticky indication records that at least one such trap has occurred, so a test can observe it. If a branch arrives in the same cycle as the counter's top value, the branch wins and no trap is raised. With the default 7-bit counter, at most 127 bytes can execute in sequence between control transfers.

Top module: `seg_window_pc`

## Requirements
- R1: While rst_n is low, and directly after it is released, fetch_addr equals the reset vector (default 0x0000), and fault_rst and fault_seen are 0.
- R2: fetch_addr always equals (base + step) modulo 2^16, where base is the 16-bit base register and step is the 7-bit step counter zero-extended.
- R3: On a clock edge with fetch_adv = 1, br_taken = 0 and the step counter below 127, the step counter increases by one, so fetch_addr rises by one.
- R4: On a clock edge with fetch_adv = 0, br_taken = 0 and the step counter below 127, fetch_addr keeps its value and fault_rst stays 0.
- R5: On a clock edge with br_taken = 1, the base register takes br_target and the step counter becomes 0, whatever fetch_adv is. fetch_addr then equals br_target and fault_rst stays 0 after that edge.
- R6: On a clock edge where the step counter is 127 and br_taken = 0, the block raises a trap whatever fetch_adv is. fault_rst is 1 for exactly the following cycle, and fetch_addr shows the reset vector from that cycle on.
- R7: On a clock edge where the step counter is 127 and br_taken = 1, the branch is taken (fetch_addr becomes br_target) and fault_rst stays 0.
- R8: fault_seen becomes 1 together with the first fault_rst pulse. It then stays 1 until rst_n is driven low.
- R9: Starting from a branch target, 126 advances produce no trap. The 127th advance brings the step counter to 127, and a trap follows on the next edge.
- R10: When base + step exceeds 0xFFFF, fetch_addr wraps to the low end of the address space (for example, target 0xFFF8 plus step 10 gives 0x0002).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_adv | input | 1 | One byte was fetched; advance the step counter |
| br_taken | input | 1 | A control transfer is taken this cycle |
| br_target | input | 16 | Destination address of the control transfer |
| fetch_addr | output | 16 | Current fetch address, base plus step |
| fault_rst | output | 1 | One-cycle trap request that resets the core |
| fault_seen | output | 1 | Sticky record that a trap has occurred |

## Verification
The hardest situation to reach is the step counter sitting at its top value. It takes 127 uninterrupted advances after a branch, with no other control transfer in between. Once there, either a trap or a last-moment branch must follow. The stimulus issues a branch, then exactly 126 advances with no trap expected. One more advance lands on the top value. From there the stimulus either idles, keeps advancing, or branches on that very edge, so the trap path and the branch-priority path are both exercised. A queue-based scoreboard predicts fetch_addr, fault_rst and fault_seen for every cycle. Separate branch targets near 0xFFFF exercise the address wrap.

// File: rtl/swpc_pkg.sv
package swpc_pkg;

   // Action chosen by the control unit for the coming clock edge
   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_STEP   = 2'd1,
      ACT_BRANCH = 2'd2,
      ACT_TRAP   = 2'd3
   } swpc_act_e;

   // Adder implementations available to the address generator
   localparam int unsigned ADD_FLAT  = 0;
   localparam int unsigned ADD_SPLIT = 1;

   localparam int unsigned DEF_ADDR_W = 16;
   localparam int unsigned DEF_STEP_W = 7;

endpackage

// File: rtl/swpc_ctrl.sv
module swpc_ctrl
   import swpc_pkg::*;
#(
   parameter int unsigned ADDR_W = DEF_ADDR_W
) (
   input  logic              fetch_adv,
   input  logic              br_taken,
   input  logic [ADDR_W-1:0] br_target,
   input  logic              step_at_top,
   input  logic [ADDR_W-1:0] reset_vec,
   output swpc_act_e         act,
   output logic              base_load,
   output logic [ADDR_W-1:0] base_val,
   output logic              step_clr,
   output logic              step_inc,
   output logic              trap
);

   // Priority: branch, then trap, then step, then hold
   always_comb begin
      if (br_taken)          act = ACT_BRANCH;
      else if (step_at_top)  act = ACT_TRAP;
      else if (fetch_adv)    act = ACT_STEP;
      else                   act = ACT_HOLD;
   end

   always_comb begin
      base_load = 1'b0;
      base_val  = br_target;
      step_clr  = 1'b0;
      step_inc  = 1'b0;
      trap      = 1'b0;
      unique case (act)
         ACT_BRANCH: begin
            base_load = 1'b1;
            base_val  = br_target;
            step_clr  = 1'b1;
         end
         ACT_TRAP: begin
            base_load = 1'b1;
            base_val  = reset_vec;
            step_clr  = 1'b1;
            trap      = 1'b1;
         end
         ACT_STEP: begin
            step_inc  = 1'b1;
         end
         default: begin
            base_load = 1'b0;
         end
      endcase
   end

   // R7: a branch on the top step value never produces a trap
   always_comb begin
      if (br_taken) begin
         AST_BRANCH_BEATS_TRAP: assert (!trap); // R7
      end
   end

endmodule

// File: rtl/swpc_base.sv
module swpc_base #(
   parameter int unsigned       ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   output logic [ADDR_W-1:0] base
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     base <= RESET_VEC;
      else if (load)  base <= load_val;
   end

   AST_BASE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(base)); // R4

endmodule

// File: rtl/swpc_step.sv
module swpc_step #(
   parameter int unsigned STEP_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   output logic [STEP_W-1:0] step,
   output logic              at_top
);

   localparam logic [STEP_W-1:0] STEP_TOP = {STEP_W{1'b1}};
   localparam logic [STEP_W-1:0] STEP_ONE = {{(STEP_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      step <= '0;
      else if (clr)    step <= '0;
      else if (inc)    step <= step + STEP_ONE;
   end

   assign at_top = (step == STEP_TOP);

   // R6: the counter is never allowed to roll over from its top value
   AST_NO_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
      (at_top && !clr) |=> at_top); // R6

   AST_STEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (step == '0)); // R5

endmodule

// File: rtl/swpc_addgen.sv
module swpc_addgen
   import swpc_pkg::*;
#(
   parameter int unsigned ADDR_W   = DEF_ADDR_W,
   parameter int unsigned STEP_W   = DEF_STEP_W,
   parameter int unsigned ADD_KIND = ADD_SPLIT
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [STEP_W-1:0] step,
   output logic [ADDR_W-1:0] addr
);

   localparam int unsigned HI_W = ADDR_W - STEP_W;

   generate
      if (ADD_KIND == ADD_FLAT) begin : g_flat
         // Single full-width adder; carry out of the top bit is dropped
         logic [ADDR_W-1:0] step_ext;
         assign step_ext = {{HI_W{1'b0}}, step};
         assign addr     = base + step_ext;
      end else begin : g_split
         // Narrow adder on the low slice plus an incrementer on the upper slice
         logic [STEP_W:0]   lo_sum;
         logic [HI_W-1:0]   hi_base;
         logic [HI_W-1:0]   hi_inc;
         logic [HI_W-1:0]   hi_one;
         assign lo_sum  = {1'b0, base[STEP_W-1:0]} + {1'b0, step};
         assign hi_base = base[ADDR_W-1:STEP_W];
         assign hi_one  = {{(HI_W-1){1'b0}}, 1'b1};
         assign hi_inc  = hi_base + hi_one;
         assign addr    = {(lo_sum[STEP_W] ? hi_inc : hi_base), lo_sum[STEP_W-1:0]};
      end
   endgenerate

   // R2: with a zero step the address is exactly the base
   always_comb begin
      if (step == '0) begin
         AST_ZERO_STEP_ADDR: assert (addr == base); // R2
      end
   end

endmodule

// File: rtl/swpc_fault.sv
module swpc_fault (
   input  logic clk,
   input  logic rst_n,
   input  logic trap,
   output logic fault_rst,
   output logic fault_seen
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_rst  <= 1'b0;
         fault_seen <= 1'b0;
      end else begin
         fault_rst  <= trap;
         if (trap) fault_seen <= 1'b1;
      end
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_rst |=> !fault_rst); // R6

   AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fault_seen |=> fault_seen); // R8

   AST_SEEN_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_rst |-> fault_seen); // R8

endmodule

// File: rtl/seg_window_pc.sv
module seg_window_pc
   import swpc_pkg::*;
#(
   parameter int unsigned       ADDR_W    = DEF_ADDR_W,
   parameter int unsigned       STEP_W    = DEF_STEP_W,
   parameter int unsigned       ADD_KIND  = ADD_SPLIT,
   parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_adv,
   input  logic              br_taken,
   input  logic [ADDR_W-1:0] br_target,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic              fault_rst,
   output logic              fault_seen
);

   // Elaboration-time parameter checks
   generate
      if (STEP_W < 2) begin : g_chk_step_min
         $error("seg_window_pc: STEP_W must be at least 2");
      end
      if (STEP_W >= ADDR_W) begin : g_chk_step_max
         $error("seg_window_pc: STEP_W must be narrower than ADDR_W");
      end
      if (ADD_KIND != ADD_FLAT && ADD_KIND != ADD_SPLIT) begin : g_chk_kind
         $error("seg_window_pc: unknown ADD_KIND");
      end
   endgenerate

   logic [ADDR_W-1:0] base;
   logic [STEP_W-1:0] step;
   logic              step_at_top;
   swpc_act_e         act;
   logic              base_load;
   logic [ADDR_W-1:0] base_val;
   logic              step_clr;
   logic              step_inc;
   logic              trap;

   swpc_ctrl #(
      .ADDR_W      (ADDR_W)
   ) u_ctrl (
      .fetch_adv   (fetch_adv),
      .br_taken    (br_taken),
      .br_target   (br_target),
      .step_at_top (step_at_top),
      .reset_vec   (RESET_VEC),
      .act         (act),
      .base_load   (base_load),
      .base_val    (base_val),
      .step_clr    (step_clr),
      .step_inc    (step_inc),
      .trap        (trap)
   );

   swpc_base #(
      .ADDR_W    (ADDR_W),
      .RESET_VEC (RESET_VEC)
   ) u_base (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (base_load),
      .load_val  (base_val),
      .base      (base)
   );

   swpc_step #(
      .STEP_W (STEP_W)
   ) u_step (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (step_clr),
      .inc    (step_inc),
      .step   (step),
      .at_top (step_at_top)
   );

   swpc_addgen #(
      .ADDR_W   (ADDR_W),
      .STEP_W   (STEP_W),
      .ADD_KIND (ADD_KIND)
   ) u_addgen (
      .base     (base),
      .step     (step),
      .addr     (fetch_addr)
   );

   swpc_fault u_fault (
      .clk        (clk),
      .rst_n      (rst_n),
      .trap       (trap),
      .fault_rst  (fault_rst),
      .fault_seen (fault_seen)
   );

   AST_RESET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (fetch_addr == RESET_VEC && !fault_rst)); // R1

   AST_BRANCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |=> (fetch_addr == $past(br_target) && !fault_rst)); // R5

   AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_adv && !br_taken && !step_at_top)
         |=> (fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1))); // R3

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_adv && !br_taken && !step_at_top) |=> $stable(fetch_addr)); // R4

   AST_TRAP_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_at_top && !br_taken) |=> (fault_rst && fetch_addr == RESET_VEC)); // R6

   AST_NO_TRAP_ON_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |=> !fault_rst); // R7

endmodule

// File: tb/seg_window_pc_tb.sv
`timescale 1ns/1ps
module seg_window_pc_tb;

   localparam int unsigned AW = 16;
   localparam logic [AW-1:0] RV = 16'h0000;
   localparam int unsigned TOP = 127;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fetch_adv = 1'b0;
   logic          br_taken = 1'b0;
   logic [AW-1:0] br_target = '0;
   logic [AW-1:0] fetch_addr;
   logic          fault_rst;
   logic          fault_seen;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   seg_window_pc u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .fetch_adv  (fetch_adv),
      .br_taken   (br_taken),
      .br_target  (br_target),
      .fetch_addr (fetch_addr),
      .fault_rst  (fault_rst),
      .fault_seen (fault_seen)
   );

   typedef struct {
      logic [AW-1:0] addr;
      logic          frst;
      logic          seen;
      string         req;
   } exp_t;

   exp_t exp_q[$];

   // Independent model state
   logic [AW-1:0] m_base = RV;
   int unsigned   m_step = 0;
   logic          m_seen = 1'b0;

   task automatic compare(input string req, input logic [AW-1:0] a,
                          input logic fr, input logic fs);
      n_cmp++;
      if (fetch_addr !== a || fault_rst !== fr || fault_seen !== fs) begin
         n_bad++;
         $display("FAIL %s: got addr=%h rst=%b seen=%b, expected addr=%h rst=%b seen=%b",
                  req, fetch_addr, fault_rst, fault_seen, a, fr, fs);
      end
   endtask

   // Driver: apply one cycle of stimulus, predict the result of the edge
   task automatic step(input logic adv, input logic br, input logic [AW-1:0] tgt,
                       input string req);
      exp_t e;
      logic fr;
      fetch_adv = adv;
      br_taken  = br;
      br_target = tgt;
      @(posedge clk);
      fr = 1'b0;
      if (br) begin
         m_base = tgt; m_step = 0;
      end else if (m_step == TOP) begin
         m_base = RV; m_step = 0; fr = 1'b1; m_seen = 1'b1;
      end else if (adv) begin
         m_step = m_step + 1;
      end
      e.addr = AW'(m_base + AW'(m_step));
      e.frst = fr;
      e.seen = m_seen;
      e.req  = req;
      exp_q.push_back(e);
      #1;
   endtask

   // Monitor: compare at the falling edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         compare(e.req, e.addr, e.frst, e.seen);
      end
   end

   task automatic apply_reset();
      rst_n = 1'b0;
      fetch_adv = 1'b0; br_taken = 1'b0;
      m_base = RV; m_step = 0; m_seen = 1'b0;
      #1;
      compare("R1", RV, 1'b0, 1'b0);
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      compare("R1", RV, 1'b0, 1'b0);
   endtask

   initial begin
      apply_reset();
      // R4: idle holds
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, "R4");
      // R5 / R3 / R2: branch and step
      step(1'b0, 1'b1, 16'h1230, "R5");
      for (int i = 0; i < 20; i++) step(1'b1, 1'b0, '0, "R3");
      for (int i = 0; i < 6; i++) step(i[0], 1'b0, '0, "R2_R4");
      step(1'b1, 1'b1, 16'hABCD, "R5");
      // R10: wrap above 0xFFFF
      step(1'b0, 1'b1, 16'hFFF8, "R10");
      for (int i = 0; i < 20; i++) step(1'b1, 1'b0, '0, "R10");
      // R9: 126 advances, no trap, then branch away
      step(1'b0, 1'b1, 16'h4000, "R9");
      for (int i = 0; i < 126; i++) step(1'b1, 1'b0, '0, "R9");
      step(1'b0, 1'b1, 16'h4800, "R9");
      // R6 / R8: reach top, idle on it -> trap
      for (int i = 0; i < 127; i++) step(1'b1, 1'b0, '0, "R9");
      step(1'b0, 1'b0, '0, "R6");
      for (int i = 0; i < 8; i++) step(1'b0, 1'b0, '0, "R8");
      // R7: branch on the top value wins
      step(1'b0, 1'b1, 16'h6000, "R7");
      for (int i = 0; i < 127; i++) step(1'b1, 1'b0, '0, "R7");
      step(1'b1, 1'b1, 16'h7000, "R7");
      step(1'b1, 1'b0, '0, "R7");
      // R6: trap with fetch_adv still high
      step(1'b0, 1'b1, 16'h2000, "R6");
      for (int i = 0; i < 127; i++) step(1'b1, 1'b0, '0, "R6");
      step(1'b1, 1'b0, '0, "R6");
      step(1'b1, 1'b0, '0, "R6_R8");
      // R1 / R8: reset clears the sticky flag
      @(negedge clk);
      apply_reset();
      step(1'b1, 1'b0, '0, "R1_R8");
      @(negedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule